// File: doc/BRIEF.md
# Mixed-signedness numeric comparator

This block compares two binary operands by the numbers they represent rather than by their bit patterns. Each operand has its own width and its own interpretation, chosen by parameters. A signed operand is read as two's complement with its leftmost bit as the sign. An unsigned operand is never negative, and its smallest value is zero. The block drives six flags at once: equal, not-equal, less-than, less-or-equal, greater-than and greater-or-equal.

Both operands are first widened to one shared width that is one bit wider than the wider operand. An unsigned operand is padded with zeros. A signed operand is padded with copies of its sign bit. The two widened values are then compared as signed numbers. The result is purely combinational, so a caller can register it or feed it straight into its own decision logic. Typical users are datapaths that mix counters with signed offsets, or that compare fields of unequal size.

Top module: `mixed_cmp`

## Requirements
- R1: When both operands are unsigned, a value compares equal to the same value held in a different width. For example, 3'b100 against 4'b0100 gives eq_o=1, and 3'b000 against 4'b0000 gives eq_o=1.
- R2: A signed operand is read as two's complement with its top bit as the sign. For example, signed 3'b100 (-4) against signed 4'b0100 (+4) gives lt_o=1 and eq_o=0.
- R3: An unsigned operand is never negative. For example, unsigned 3'b001 against signed 4'b1111 (-1) gives gt_o=1 and lt_o=0.
- R4: eq_o is 1 exactly when the numeric values of a_in and b_in are equal.
- R5: lt_o is 1 exactly when the value of a_in is smaller than the value of b_in.
- R6: gt_o is 1 exactly when the value of a_in is larger than the value of b_in.
- R7: ne_o is always the complement of eq_o.
- R8: le_o equals lt_o OR eq_o, and it is the complement of gt_o.
- R9: ge_o is the complement of lt_o, and it equals gt_o OR eq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | A_W | Left operand; signed when A_SIGNED=1 |
| b_in | input | B_W | Right operand; signed when B_SIGNED=1 |
| eq_o | output | 1 | Values are equal |
| ne_o | output | 1 | Values differ |
| lt_o | output | 1 | a_in is less than b_in |
| le_o | output | 1 | a_in is less than or equal to b_in |
| gt_o | output | 1 | a_in is greater than b_in |
| ge_o | output | 1 | a_in is greater than or equal to b_in |

## Verification
The block holds no state. An error inside it shows up at the ports in the same cycle as the input that exposes it, and goes away when the inputs change.

A wrong extension choice is the likeliest fault, for example zero-padding a signed operand. It makes negative values read as large positive ones. That flips lt_o and gt_o only for operands whose sign bit is set. Sweeping every operand pair in every signedness combination therefore exposes it at once.

A fault in the flag derivation breaks the rule that exactly one of lt_o, eq_o and gt_o is high. It also breaks the complement pairs. Both effects are visible on the very vector that triggers the fault.

// File: rtl/mixed_cmp_pkg.sv
package mixed_cmp_pkg;

  // Width that holds either operand after extension, plus one bit so an
  // unsigned operand of the wider width stays non-negative when read signed.
  function automatic int common_width(input int wa, input int wb);
    return ((wa > wb) ? wa : wb) + 1;
  endfunction

  typedef struct packed {
    logic eq;
    logic ne;
    logic lt;
    logic le;
    logic gt;
    logic ge;
  } rel_t;

endpackage

// File: rtl/cmp_extend.sv
module cmp_extend #(
  parameter int IN_W      = 8,
  parameter int OUT_W     = 9,
  parameter bit IS_SIGNED = 1'b0
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] val_o
);
  localparam int PAD_W = OUT_W - IN_W;

  generate
    if (IS_SIGNED) begin : g_sign
      // Copy the sign bit into every added position.
      assign val_o = {{PAD_W{val_i[IN_W-1]}}, val_i};
    end else begin : g_zero
      // Unsigned values gain zeros above the original MSB.
      assign val_o = {{PAD_W{1'b0}}, val_i};
    end
  endgenerate
endmodule

// File: rtl/cmp_core.sv
module cmp_core #(
  parameter int W = 9
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic         lt_o,
  output logic         eq_o,
  output logic         gt_o
);
  // Three independent comparators. The relation block combines them,
  // and the checker cross-checks them against one another.
  always_comb begin
    lt_o = $signed(x_i) < $signed(y_i);
    gt_o = $signed(x_i) > $signed(y_i);
    eq_o = ~|(x_i ^ y_i);
  end
endmodule

// File: rtl/cmp_rel.sv
module cmp_rel
  import mixed_cmp_pkg::*;
(
  input  logic lt_i,
  input  logic eq_i,
  input  logic gt_i,
  output rel_t rel_o
);
  always_comb begin
    rel_o.eq = eq_i;
    rel_o.lt = lt_i;
    rel_o.gt = gt_i;
    rel_o.ne = lt_i | gt_i;
    rel_o.le = lt_i | eq_i;
    rel_o.ge = gt_i | eq_i;
  end
endmodule

// File: rtl/mixed_cmp.sv
module mixed_cmp
  import mixed_cmp_pkg::*;
#(
  parameter int A_W      = 8,
  parameter int B_W      = 8,
  parameter bit A_SIGNED = 1'b0,
  parameter bit B_SIGNED = 1'b0
) (
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  output logic           eq_o,
  output logic           ne_o,
  output logic           lt_o,
  output logic           le_o,
  output logic           gt_o,
  output logic           ge_o
);
  localparam int CW = common_width(A_W, B_W);

  logic [CW-1:0] a_ext;
  logic [CW-1:0] b_ext;
  logic          c_lt;
  logic          c_eq;
  logic          c_gt;
  rel_t          rel;

  cmp_extend #(.IN_W(A_W), .OUT_W(CW), .IS_SIGNED(A_SIGNED)) u_ext_a (
    .val_i(a_in),
    .val_o(a_ext)
  );

  cmp_extend #(.IN_W(B_W), .OUT_W(CW), .IS_SIGNED(B_SIGNED)) u_ext_b (
    .val_i(b_in),
    .val_o(b_ext)
  );

  cmp_core #(.W(CW)) u_core (
    .x_i (a_ext),
    .y_i (b_ext),
    .lt_o(c_lt),
    .eq_o(c_eq),
    .gt_o(c_gt)
  );

  cmp_rel u_rel (
    .lt_i (c_lt),
    .eq_i (c_eq),
    .gt_i (c_gt),
    .rel_o(rel)
  );

  assign eq_o = rel.eq;
  assign ne_o = rel.ne;
  assign lt_o = rel.lt;
  assign le_o = rel.le;
  assign gt_o = rel.gt;
  assign ge_o = rel.ge;
endmodule

// File: rtl/mixed_cmp_chk.sv
module mixed_cmp_chk #(
  parameter int A_W      = 8,
  parameter int B_W      = 8,
  parameter bit A_SIGNED = 1'b0,
  parameter bit B_SIGNED = 1'b0
) (
  input logic [A_W-1:0] a_in,
  input logic [B_W-1:0] b_in,
  input logic           eq_o,
  input logic           ne_o,
  input logic           lt_o,
  input logic           le_o,
  input logic           gt_o,
  input logic           ge_o
);
  logic a_neg;
  logic b_neg;

  always_comb begin
    a_neg = A_SIGNED && a_in[A_W-1];
    b_neg = B_SIGNED && b_in[B_W-1];
    if (!$isunknown({a_in, b_in, eq_o, ne_o, lt_o, le_o, gt_o, ge_o})) begin
      AST_ONE_RELATION: assert ($onehot({lt_o, eq_o, gt_o}));  // R4
      AST_NE_COMPL:     assert (ne_o == !eq_o);                 // R7
      AST_LE_NOT_GT:    assert (le_o == !gt_o);                 // R8
      AST_GE_NOT_LT:    assert (ge_o == !lt_o);                 // R9
      AST_NEG_BELOW:    assert (!(a_neg && !b_neg) || lt_o);    // R2
      AST_UNS_ABOVE:    assert (!(!a_neg && b_neg) || gt_o);    // R3
    end
  end
endmodule

bind mixed_cmp mixed_cmp_chk #(
  .A_W(A_W), .B_W(B_W), .A_SIGNED(A_SIGNED), .B_SIGNED(B_SIGNED)
) u_chk (
  .a_in(a_in), .b_in(b_in),
  .eq_o(eq_o), .ne_o(ne_o), .lt_o(lt_o),
  .le_o(le_o), .gt_o(gt_o), .ge_o(ge_o)
);

// File: tb/mixed_cmp_tb.sv
module mixed_cmp_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Instances: uu, us, su, ss with A 3 bits / B 4 bits; wide: A 12 signed, B 9 unsigned
  logic [2:0]  a_uu, a_us, a_su, a_ss;
  logic [3:0]  b_uu, b_us, b_su, b_ss;
  logic [11:0] a_w;
  logic [8:0]  b_w;
  logic [5:0]  r_uu, r_us, r_su, r_ss, r_w;  // {eq,ne,lt,le,gt,ge}

  mixed_cmp #(.A_W(3), .B_W(4), .A_SIGNED(0), .B_SIGNED(0)) u_dut (
    .a_in(a_uu), .b_in(b_uu), .eq_o(r_uu[5]), .ne_o(r_uu[4]), .lt_o(r_uu[3]),
    .le_o(r_uu[2]), .gt_o(r_uu[1]), .ge_o(r_uu[0]));
  mixed_cmp #(.A_W(3), .B_W(4), .A_SIGNED(0), .B_SIGNED(1)) u_dut_us (
    .a_in(a_us), .b_in(b_us), .eq_o(r_us[5]), .ne_o(r_us[4]), .lt_o(r_us[3]),
    .le_o(r_us[2]), .gt_o(r_us[1]), .ge_o(r_us[0]));
  mixed_cmp #(.A_W(3), .B_W(4), .A_SIGNED(1), .B_SIGNED(0)) u_dut_su (
    .a_in(a_su), .b_in(b_su), .eq_o(r_su[5]), .ne_o(r_su[4]), .lt_o(r_su[3]),
    .le_o(r_su[2]), .gt_o(r_su[1]), .ge_o(r_su[0]));
  mixed_cmp #(.A_W(3), .B_W(4), .A_SIGNED(1), .B_SIGNED(1)) u_dut_ss (
    .a_in(a_ss), .b_in(b_ss), .eq_o(r_ss[5]), .ne_o(r_ss[4]), .lt_o(r_ss[3]),
    .le_o(r_ss[2]), .gt_o(r_ss[1]), .ge_o(r_ss[0]));
  mixed_cmp #(.A_W(12), .B_W(9), .A_SIGNED(1), .B_SIGNED(0)) u_dut_w (
    .a_in(a_w), .b_in(b_w), .eq_o(r_w[5]), .ne_o(r_w[4]), .lt_o(r_w[3]),
    .le_o(r_w[2]), .gt_o(r_w[1]), .ge_o(r_w[0]));

  function automatic int num(input logic [31:0] bits, input int w, input bit s);
    int v;
    v = 0;
    for (int i = 0; i < w; i++) if (bits[i]) v += (1 << i);
    if (s && bits[w-1]) v -= (1 << w);
    return v;
  endfunction

  function automatic logic [5:0] expect6(input int va, input int vb);
    return {va == vb, va != vb, va < vb, va <= vb, va > vb, va >= vb};
  endfunction

  task automatic chk1(input string tag, input logic got, input logic exp,
                      input int va, input int vb);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s a=%0d b=%0d actual=%b expected=%b", tag, va, vb, got, exp);
    end
  endtask

  task automatic chk6(input logic [5:0] got, input int va, input int vb);
    logic [5:0] e;
    e = expect6(va, vb);
    chk1("R4 eq", got[5], e[5], va, vb);
    chk1("R7 ne", got[4], e[4], va, vb);
    chk1("R5 lt", got[3], e[3], va, vb);
    chk1("R8 le", got[2], e[2], va, vb);
    chk1("R6 gt", got[1], e[1], va, vb);
    chk1("R9 ge", got[0], e[0], va, vb);
  endtask

  initial begin
    a_uu = '0; b_uu = '0; a_us = '0; b_us = '0;
    a_su = '0; b_su = '0; a_ss = '0; b_ss = '0;
    a_w  = '0; b_w  = '0;
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    // R1: zero against zero in different widths
    chk1("R1 zero eq", r_uu[5], 1'b1, 0, 0);

    // R1: unsigned 100 against 0100
    @(posedge clk); a_uu = 3'b100; b_uu = 4'b0100;
    @(negedge clk);
    chk1("R1 eq", r_uu[5], 1'b1, 4, 4);
    chk1("R1 lt", r_uu[3], 1'b0, 4, 4);

    // R2: signed 100 (-4) against signed 0100 (+4)
    @(posedge clk); a_ss = 3'b100; b_ss = 4'b0100;
    @(negedge clk);
    chk1("R2 lt", r_ss[3], 1'b1, -4, 4);
    chk1("R2 eq", r_ss[5], 1'b0, -4, 4);

    // R3: unsigned 001 against signed 1111 (-1)
    @(posedge clk); a_us = 3'b001; b_us = 4'b1111;
    @(negedge clk);
    chk1("R3 gt", r_us[1], 1'b1, 1, -1);
    chk1("R3 lt", r_us[3], 1'b0, 1, -1);

    // Exhaustive sweep of all four signedness combinations
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 16; j++) begin
        @(posedge clk);
        a_uu = i[2:0]; a_us = i[2:0]; a_su = i[2:0]; a_ss = i[2:0];
        b_uu = j[3:0]; b_us = j[3:0]; b_su = j[3:0]; b_ss = j[3:0];
        @(negedge clk);
        chk6(r_uu, num(i, 3, 0), num(j, 4, 0));
        chk6(r_us, num(i, 3, 0), num(j, 4, 1));
        chk6(r_su, num(i, 3, 1), num(j, 4, 0));
        chk6(r_ss, num(i, 3, 1), num(j, 4, 1));
      end
    end

    // Wide pair: directed extremes, then random values
    @(posedge clk); a_w = 12'h800; b_w = 9'h000;
    @(negedge clk); chk6(r_w, num(32'h800, 12, 1), 0);
    @(posedge clk); a_w = 12'h1FF; b_w = 9'h1FF;
    @(negedge clk); chk6(r_w, 511, 511);
    @(posedge clk); a_w = 12'hFFF; b_w = 9'h1FF;
    @(negedge clk); chk6(r_w, -1, 511);
    for (int k = 0; k < 300; k++) begin
      logic [31:0] ra;
      logic [31:0] rb;
      ra = $urandom;
      rb = $urandom;
      if (k % 4 == 0) rb[11:0] = ra[11:0];  // force some equal values
      if (k % 4 == 0) ra[11] = 1'b0;
      @(posedge clk); a_w = ra[11:0]; b_w = rb[8:0];
      @(negedge clk);
      chk6(r_w, num({20'd0, ra[11:0]}, 12, 1), num({23'd0, rb[8:0]}, 9, 0));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule